// File: doc/BRIEF.md
# I2C-Controlled Four-Way Channel Selector

This block is an I2C target that owns a four-bit channel-enable register. Each bit of the register would close an external pass gate that joins the upstream SCL/SDA pair to one of four downstream pairs. Any subset of the four may be enabled together, including none or all. A bus controller writes one data byte to choose the subset and reads one byte back. The read byte holds the current enables and the interrupt state of the four downstream segments.

The four active-low interrupt lines from the downstream segments are merged into one active-low output. That output is low whenever at least one segment requests attention. The block also has an active-low reset. It drops every channel and returns the protocol engine to idle, so a segment that holds its bus low can be cut off and recovered.

SCL and SDA are oversampled by a system clock at least 16 times the SCL rate. SDA is driven only as an open-drain pull-down enable. The two address-select pins give the two low bits of the target address, so four selectors can share one upstream bus.

Top module: `chan_sel_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `ch_en` becomes 4'b0000 and `sda_oe` becomes 0 by the next edge. Any half-finished write is discarded: a later stop without a new write leaves `ch_en` at zero.
- R2: The target's 7-bit address is {5'b11100, addr_sel[1], addr_sel[0]}, compared against the first seven bits after a start (MSB first). The target pulls SDA low in the ninth clock only when these match. A mismatching address gets no ACK and changes nothing.
- R3: With the eighth address bit (R/W) at 0, the next byte is acknowledged and its bits [3:0] become the channel enables. Bit i enables channel i, and every one of the 16 combinations is accepted.
- R4: A written value does not appear on `ch_en` before the next stop condition, and it appears within a few clocks after that stop, even if a repeated start came in between.
- R5: With R/W at 1, the target returns bytes MSB first. Bits [3:0] equal `ch_en`, and bit 4+i equals the inverse of `irq_n_i[i]` at the time the byte is loaded. A controller ACK makes it send the byte again.
- R6: After the controller NACKs a read byte, the target leaves SDA released until the next start, so further clocked bits read as 1.
- R7: `irq_n_o` is low exactly when at least one of `irq_n_i[3:0]` is low.
- R8: Only the first data byte of a write is taken. Any later byte in the same transaction is not acknowledged and does not alter the pending value.
- R9: A stop condition in the middle of a data byte ends the transaction with no effect on `ch_en`. Each start, including a repeated start, restarts address reception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16x the SCL rate |
| rst_n | input | 1 | Active-low reset, sampled on the clock |
| scl_i | input | 1 | Upstream SCL level |
| sda_i | input | 1 | Upstream SDA level |
| sda_oe | output | 1 | 1 pulls upstream SDA low (open drain) |
| addr_sel | input | 2 | Low two bits of the target address |
| ch_en | output | 4 | Channel enables, bit i closes channel i |
| irq_n_i | input | 4 | Active-low interrupt from each downstream channel |
| irq_n_o | output | 1 | Active-low combined interrupt |

## Verification
A wrong bit counter or protocol state shows up within one byte time at the ports. It appears as a missing or misplaced ACK pulse on `sda_oe`, or as read data shifted by a bit. A fault in the pending-write path shows on `ch_en` only at the stop that ends the transaction. For that reason the bench checks `ch_en` both just before and just after every stop. Faults in the interrupt merge appear on `irq_n_o` combinationally, and a full sweep of all sixteen input patterns exposes them.

// File: rtl/chsel_pkg.sv
// Package: shared constants and the protocol state type for the channel selector.
// Assumes exactly four channels so that enables and interrupt flags fill one byte.
package chsel_pkg;
    localparam int NCH      = 4;
    localparam int BYTE_W   = 8;
    localparam int CNT_W    = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK,
        ST_SKIP
    } tgt_state_t;
endpackage

// File: rtl/chsel_bus_sync.sv
// Module: brings SCL and SDA into the clock domain through a flip-flop chain and
// derives edge and start/stop pulses. Assumes clk is at least 16x the SCL rate.
// Reset holds the chain at the idle-bus level (both high) so no edge appears.
module chsel_bus_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic sda_lvl
);
    localparam int PIPE_W = SYNC_STAGES + 1;

    logic [PIPE_W-1:0] scl_pipe;
    logic [PIPE_W-1:0] sda_pipe;
    logic scl_s, scl_q, sda_s, sda_q;

    // Shift the raw bus levels through the synchroniser plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[PIPE_W-2:0], scl_i};
            sda_pipe <= {sda_pipe[PIPE_W-2:0], sda_i};
        end
    end

    // Select the synchronised level and its previous sample.
    always_comb begin
        scl_s = scl_pipe[SYNC_STAGES-1];
        scl_q = scl_pipe[SYNC_STAGES];
        sda_s = sda_pipe[SYNC_STAGES-1];
        sda_q = sda_pipe[SYNC_STAGES];
    end

    // Decode edges and the two SDA-while-SCL-high conditions.
    always_comb begin
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
        sda_lvl   = sda_s;
    end
endmodule

// File: rtl/chsel_irq.sv
// Module: merges the active-low interrupt lines of all channels into one
// active-low output and provides active-high flags for the read byte.
// Purely combinational; assumes the inputs are already stable levels.
module chsel_irq
    import chsel_pkg::*;
(
    input  logic [NCH-1:0] irq_n_i,
    output logic           irq_n_o,
    output logic [NCH-1:0] irq_act
);
    // Any low input pulls the merged output low; flags are the inverted levels.
    always_comb begin
        irq_n_o = &irq_n_i;
        irq_act = ~irq_n_i;
    end
endmodule

// File: rtl/chsel_target.sv
// Module: I2C target protocol engine and channel-enable register.
// Assumes one-cycle edge/start/stop pulses from chsel_bus_sync. SDA drive
// changes only on a detected SCL fall. Start and stop override every state.
// A written byte is held pending and committed to the enables at the stop.
module chsel_target
    import chsel_pkg::*;
#(
    parameter logic [4:0] ADDR_PREFIX = 5'b11100
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           scl_rise,
    input  logic           scl_fall,
    input  logic           start_det,
    input  logic           stop_det,
    input  logic           sda_lvl,
    input  logic [1:0]     addr_sel,
    input  logic [NCH-1:0] irq_act,
    output logic [NCH-1:0] ch_en,
    output logic           sda_oe
);
    tgt_state_t         state;
    logic [CNT_W-1:0]   cnt;
    logic [BYTE_W-1:0]  sh;
    logic [BYTE_W-1:0]  tx;
    logic [BYTE_W-1:0]  rd_byte;
    logic               rw;
    logic               mnack;
    logic [1:0]         addr_lat;
    logic [NCH-1:0]     pend;
    logic               pend_v;

    // Byte returned on reads: interrupt flags above the current enables.
    always_comb rd_byte = {irq_act, ch_en};

    // Protocol sequencing, SDA drive and the pending/committed enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            sh       <= '0;
            tx       <= '0;
            rw       <= 1'b0;
            mnack    <= 1'b0;
            addr_lat <= '0;
            pend     <= '0;
            pend_v   <= 1'b0;
            ch_en    <= '0;
            sda_oe   <= 1'b0;
        end else if (start_det) begin
            state    <= ST_ADDR;
            cnt      <= '0;
            sda_oe   <= 1'b0;
            addr_lat <= addr_sel;
        end else if (stop_det) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            sda_oe <= 1'b0;
            pend_v <= 1'b0;
            if (pend_v) ch_en <= pend;
        end else begin
            case (state)
                ST_ADDR: begin
                    if (scl_rise) begin
                        sh  <= {sh[BYTE_W-2:0], sda_lvl};
                        cnt <= cnt + 4'd1;
                    end else if (scl_fall && cnt == 4'd8) begin
                        cnt <= '0;
                        if (sh[7:1] == {ADDR_PREFIX, addr_lat}) begin
                            rw     <= sh[0];
                            sda_oe <= 1'b1;
                            state  <= ST_AACK;
                        end else begin
                            state <= ST_SKIP;
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall) begin
                        cnt <= '0;
                        if (rw) begin
                            tx     <= rd_byte;
                            sda_oe <= ~rd_byte[7];
                            state  <= ST_RDATA;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= ST_WDATA;
                        end
                    end
                end
                ST_WDATA: begin
                    if (scl_rise) begin
                        sh  <= {sh[BYTE_W-2:0], sda_lvl};
                        cnt <= cnt + 4'd1;
                    end else if (scl_fall && cnt == 4'd8) begin
                        pend   <= sh[NCH-1:0];
                        pend_v <= 1'b1;
                        sda_oe <= 1'b1;
                        cnt    <= '0;
                        state  <= ST_WACK;
                    end
                end
                ST_WACK: begin
                    if (scl_fall) begin
                        sda_oe <= 1'b0;
                        state  <= ST_SKIP;
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        cnt <= cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (cnt == 4'd8) begin
                            sda_oe <= 1'b0;
                            cnt    <= '0;
                            state  <= ST_RACK;
                        end else begin
                            tx     <= {tx[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~tx[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        mnack <= sda_lvl;
                    end else if (scl_fall) begin
                        cnt <= '0;
                        if (mnack) begin
                            state <= ST_SKIP;
                        end else begin
                            tx     <= rd_byte;
                            sda_oe <= ~rd_byte[7];
                            state  <= ST_RDATA;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // The bit counter never runs past one byte (R2, R3).
    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= 4'd8);

    // Enables move only in the cycle after a stop pulse from the synchroniser (R4).
    p_commit_at_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ch_en) |-> $past(stop_det));

    // SDA is pulled only during an ACK or a read data bit (R6).
    p_oe_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (state == ST_AACK || state == ST_WACK || state == ST_RDATA));

    // Address ACK starts only after a full byte has been counted (R2).
    p_ack_after_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_AACK && $past(state) != ST_AACK) |-> $past(cnt) == 4'd8);

    // Every start puts the engine back at the first address bit (R9).
    p_start_restarts_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start_det) |-> (state == ST_ADDR && cnt == 4'd0 && !sda_oe));
endmodule

// File: rtl/chan_sel_ctrl.sv
// Module: top of the I2C channel selector. Connects the bus synchroniser, the
// target protocol engine and the interrupt merge. Assumes clk >= 16x SCL rate
// and an external open-drain SDA driver controlled by sda_oe.
module chan_sel_ctrl
    import chsel_pkg::*;
#(
    parameter logic [4:0] ADDR_PREFIX = 5'b11100,
    parameter int         SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           scl_i,
    input  logic           sda_i,
    output logic           sda_oe,
    input  logic [1:0]     addr_sel,
    output logic [NCH-1:0] ch_en,
    input  logic [NCH-1:0] irq_n_i,
    output logic           irq_n_o
);
    logic scl_rise, scl_fall, start_det, stop_det, sda_lvl;
    logic [NCH-1:0] irq_act;

    chsel_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_lvl   (sda_lvl)
    );

    chsel_irq u_irq (
        .irq_n_i (irq_n_i),
        .irq_n_o (irq_n_o),
        .irq_act (irq_act)
    );

    chsel_target #(.ADDR_PREFIX(ADDR_PREFIX)) u_tgt (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_lvl   (sda_lvl),
        .addr_sel  (addr_sel),
        .irq_act   (irq_act),
        .ch_en     (ch_en),
        .sda_oe    (sda_oe)
    );
endmodule

// File: tb/sim_chan_sel_ctrl.sv
// Bench: drives an I2C controller model against chan_sel_ctrl and sweeps
// addresses, enable values and interrupt patterns with computed expectations.
module sim_chan_sel_ctrl;
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] addr_sel = 2'd0;
    logic [3:0] irq_n_i = 4'hF;
    logic       sda_oe;
    logic [3:0] ch_en;
    logic       irq_n_o;
    logic       sda_bus;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    chan_sel_ctrl u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_bus),
        .sda_oe   (sda_oe),
        .addr_sel (addr_sel),
        .ch_en    (ch_en),
        .irq_n_i  (irq_n_i),
        .irq_n_o  (irq_n_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    tick(Q);
        scl_m = 1'b1; tick(2 * Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        b = sda_bus;  tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic write_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(b);
        ack = ~b;
    endtask

    task automatic read_byte(output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            d[i] = b;
        end
    endtask

    function automatic logic [6:0] dev_addr(input logic [1:0] sel);
        return {5'b11100, sel};
    endfunction

    // Watchdog: a hung run counts as one failed check and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic       ack;
        logic [7:0] rb;
        logic [3:0] prev;

        // R1: reset state.
        tick(5);
        check(ch_en == 4'h0, "R1 reset ch_en", ch_en, 0);
        check(sda_oe == 1'b0, "R1 reset sda_oe", sda_oe, 0);
        rst_n = 1'b1;
        tick(5);

        // R7: all sixteen interrupt input patterns.
        for (int p = 0; p < 16; p++) begin
            irq_n_i = p[3:0];
            tick(2);
            check(irq_n_o == ((p == 15) ? 1'b1 : 1'b0), "R7 irq merge", irq_n_o, (p == 15));
        end
        irq_n_i = 4'hF;

        // R2: matching and mismatching addresses for every pin setting.
        for (int s = 0; s < 4; s++) begin
            addr_sel = s[1:0];
            for (int k = 0; k < 9; k++) begin
                logic [6:0] a;
                bit         exp_ack;
                if (k < 4) a = {5'b11100, k[1:0]};
                else       a = {5'b11100 ^ (5'b00001 << (k - 4)), s[1:0]};
                exp_ack = (a == dev_addr(s[1:0]));
                bus_start();
                write_byte({a, 1'b0}, ack);
                bus_stop();
                check(ack == exp_ack, "R2 address ack", ack, exp_ack);
            end
        end
        check(ch_en == 4'h0, "R2 address-only has no effect", ch_en, 0);

        // R3, R4, R5: every enable combination, written then read back.
        addr_sel = 2'd2;
        prev = 4'h0;
        for (int v = 0; v < 16; v++) begin
            bus_start();
            write_byte({dev_addr(2'd2), 1'b0}, ack);
            write_byte({4'h0, v[3:0]}, ack);
            check(ack == 1'b1, "R3 data ack", ack, 1);
            check(ch_en == prev, "R4 held until stop", ch_en, prev);
            bus_stop();
            tick(4);
            check(ch_en == v[3:0], "R3 enables after stop", ch_en, v);
            prev = v[3:0];

            irq_n_i = v[3:0] ^ 4'h6;
            bus_start();
            write_byte({dev_addr(2'd2), 1'b1}, ack);
            read_byte(rb);
            send_bit(1'b1);
            bus_stop();
            check(rb == {~(v[3:0] ^ 4'h6), v[3:0]}, "R5 read byte", rb, {~(v[3:0] ^ 4'h6), v[3:0]});
        end

        // R5, R6: ACKed read repeats the byte; after NACK the target stays silent.
        irq_n_i = 4'b1010;
        bus_start();
        write_byte({dev_addr(2'd2), 1'b1}, ack);
        read_byte(rb);
        send_bit(1'b0);
        check(rb == {4'b0101, 4'hF}, "R5 first read byte", rb, {4'b0101, 4'hF});
        read_byte(rb);
        send_bit(1'b1);
        check(rb == {4'b0101, 4'hF}, "R5 repeated read byte", rb, {4'b0101, 4'hF});
        read_byte(rb);
        check(rb == 8'hFF, "R6 released after NACK", rb, 8'hFF);
        bus_stop();
        irq_n_i = 4'hF;

        // R8: a second data byte is refused and ignored.
        bus_start();
        write_byte({dev_addr(2'd2), 1'b0}, ack);
        write_byte(8'h0A, ack);
        check(ack == 1'b1, "R8 first byte ack", ack, 1);
        write_byte(8'h05, ack);
        check(ack == 1'b0, "R8 second byte nack", ack, 0);
        bus_stop();
        tick(4);
        check(ch_en == 4'hA, "R8 first byte kept", ch_en, 4'hA);

        // R9: stop in the middle of a data byte changes nothing.
        bus_start();
        write_byte({dev_addr(2'd2), 1'b0}, ack);
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_stop();
        tick(4);
        check(ch_en == 4'hA, "R9 mid-byte stop", ch_en, 4'hA);

        // R4, R9: repeated start to a foreign address, pending value lands at stop.
        bus_start();
        write_byte({dev_addr(2'd2), 1'b0}, ack);
        write_byte(8'h03, ack);
        bus_start();
        write_byte({dev_addr(2'd1), 1'b0}, ack);
        check(ack == 1'b0, "R9 restart address mismatch", ack, 0);
        check(ch_en == 4'hA, "R4 not yet applied", ch_en, 4'hA);
        bus_stop();
        tick(4);
        check(ch_en == 4'h3, "R4 applied at stop after restart", ch_en, 4'h3);

        // R1: reset in the middle of a write discards it.
        bus_start();
        write_byte({dev_addr(2'd2), 1'b0}, ack);
        write_byte(8'h0F, ack);
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(2);
        check(ch_en == 4'h0, "R1 reset mid-write", ch_en, 0);
        check(sda_oe == 1'b0, "R1 reset releases sda", sda_oe, 0);
        bus_stop();
        tick(4);
        check(ch_en == 4'h0, "R1 pending discarded", ch_en, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule